// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block keeps the burst settings that a memory controller writes into an SDRAM mode register, and from them produces the column address of every beat of a read or write burst. A load strobe presents a mode op-code with its bank bits. The block checks the code, and if it is legal it stores the burst length, the ordering, the CAS latency and the write mode. The CAS latency and the write mode are driven out for the rest of the controller to use.

A start strobe begins a burst at a given column and says whether it is a write. Each step enable moves to the next beat's column. A terminate strobe ends the burst early. Bursts use either wrap-around sequential order or XOR-interleaved order, with a length of 1, 2, 4 or 8. A full-page burst runs through all 1024 columns and wraps for as long as it is not terminated. All outputs come from registers.

Top module: `burst_col_gen`

## Requirements
- R1: After reset the outputs are col_valid=0, col_last=0, mode_err=0, cas_lat=2 and single_write=0. The stored burst is length 1, sequential.
- R2: A legal mode load updates cas_lat and single_write on the next cycle. Op-code field layout: bits 2..0 length (000=1, 001=2, 010=4, 011=8, 111=full page), bit 3 order (0 sequential, 1 interleaved), bits 6..4 latency (010=2, 011=3), bit 9 write mode (1 = single-location writes). Bits 8,7,11,10 and the bank bits must be zero.
- R3: Any reserved op-code sets mode_err on the next cycle and leaves every stored setting unchanged. The reserved codes are a length code of 100, 101 or 110; a latency code other than 010 or 011; a nonzero must-be-zero bit; or full page with interleave. A later legal load clears mode_err.
- R4: One cycle after burst_start, col_out equals the start column and col_valid=1. col_last=1 at that point only if the burst length is 1.
- R5: In sequential order, the low log2(length) column bits count up from the start value and wrap. The upper bits keep their start value. Example: length 8 from 5 gives 5,6,7,0,1,2,3,4.
- R6: In interleaved order, beat k has the column start XOR k. Example: length 8 from 5 gives 5,4,7,6,1,0,3,2.
- R7: col_last is 1 only on the final beat of a fixed-length burst. A step on that beat clears col_valid on the next cycle.
- R8: A full-page burst counts up modulo 1024 across all column bits. It never raises col_last and runs until it is terminated.
- R9: burst_stop clears col_valid and col_last on the next cycle. A burst_start in the same cycle takes priority and begins a new burst.
- R10: While col_valid=1 and step_en=0, with no start or stop, col_out and col_valid hold.
- R11: When single-location writes are selected, a write burst has one beat. A read burst still uses the programmed length.
- R12: A burst keeps the length and ordering that were stored when it started, even if a mode load happens during the burst.
- R13: A burst_start during a running burst restarts at the new column with the current settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Load strobe for the mode op-code |
| mode_op | input | 12 | Mode op-code |
| mode_ba | input | 2 | Bank bits sent with the load; must be zero |
| burst_start | input | 1 | Start a burst at start_col |
| burst_is_write | input | 1 | The burst being started is a write |
| start_col | input | 10 | Starting column |
| step_en | input | 1 | Advance to the next beat |
| burst_stop | input | 1 | Terminate the burst |
| col_out | output | 10 | Current column |
| col_valid | output | 1 | A burst beat is presented |
| col_last | output | 1 | Current beat is the final one |
| cas_lat | output | 2 | Stored CAS latency in cycles |
| single_write | output | 1 | Single-location write mode stored |
| mode_err | output | 1 | The last mode load was rejected |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. This holds for decoded settings and mode_err after a load, for the first column after a start, for each next column after a step, and for the drop of col_valid after a terminate or a final step. The bench changes inputs shortly after a rising edge. It then waits for the next rising edge plus a small offset before it compares outputs, so each comparison sees the state of the edge under test. Expected columns come from the ordering rules written out in the requirements. They are computed per beat from the start column and the beat count.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int OP_W   = 12;
  localparam int BA_W   = 2;
  localparam int COL_W  = 10;
  localparam int LG_W   = 2;

  // stored burst settings
  typedef struct packed {
    logic [LG_W-1:0] len_lg;   // log2 of fixed burst length
    logic            full_pg;  // full-page burst
    logic            ilv;      // interleaved order
    logic [1:0]      cl;       // CAS latency
    logic            wr_single;
  } mode_t;

  localparam mode_t MODE_RST = '{len_lg: '0, full_pg: 1'b0, ilv: 1'b0,
                                 cl: 2'd2, wr_single: 1'b0};

  function automatic logic code_legal(input logic [OP_W-1:0] op,
                                      input logic [BA_W-1:0] ba);
    logic ok;
    ok = 1'b1;
    case (op[2:0])
      3'b000, 3'b001, 3'b010, 3'b011: ;
      3'b111: if (op[3]) ok = 1'b0;
      default: ok = 1'b0;
    endcase
    if (op[6:4] != 3'b010 && op[6:4] != 3'b011) ok = 1'b0;
    if (op[8:7] != 2'b00 || op[11:10] != 2'b00) ok = 1'b0;
    if (ba != '0) ok = 1'b0;
    return ok;
  endfunction

  function automatic mode_t code_decode(input logic [OP_W-1:0] op);
    mode_t m;
    m.len_lg    = op[1:0];
    m.full_pg   = (op[2:0] == 3'b111);
    m.ilv       = op[3];
    m.cl        = op[5:4];
    m.wr_single = op[9];
    return m;
  endfunction

endpackage

// File: rtl/mode_store.sv
module mode_store
  import burst_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int BAW = BA_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [OPW-1:0] op,
  input  logic [BAW-1:0] ba,
  output mode_t          mode_q,
  output logic           err_q
);

  logic legal;
  assign legal = code_legal(op, ba);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RST;
      err_q  <= 1'b0;
    end else if (load) begin
      err_q <= !legal;
      if (legal) mode_q <= code_decode(op);
    end
  end

  AST_RSVD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (load && !legal) |=> ($stable(mode_q) && err_q)); // R3

  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (mode_q.cl == 2'd2 || mode_q.cl == 2'd3)); // R2

endmodule

// File: rtl/col_order.sv
module col_order #(
  parameter int CW = 10
) (
  input  logic [CW-1:0] base,
  input  logic [CW-1:0] beat,
  input  logic [CW-1:0] mask,
  input  logic          full_pg,
  input  logic          ilv,
  output logic [CW-1:0] addr
);

  logic [CW-1:0] sum;
  assign sum = base + beat;

  for (genvar i = 0; i < CW; i++) begin : g_bit
    always_comb begin
      if (full_pg)      addr[i] = sum[i];
      else if (!mask[i]) addr[i] = base[i];
      else if (ilv)     addr[i] = base[i] ^ beat[i];
      else              addr[i] = sum[i];
    end
  end

endmodule

// File: rtl/beat_seq.sv
module beat_seq
  import burst_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  mode_t         mode,
  input  logic          start,
  input  logic          is_wr,
  input  logic [CW-1:0] start_col,
  input  logic          step,
  input  logic          stop,
  output logic [CW-1:0] col_q,
  output logic          valid_q,
  output logic          last_q
);

  logic [CW-1:0] base_q, beat_q, mask_q, nb, nxt, s_mask;
  logic          fp_q, ilv_q, s_fp, one_beat;

  assign one_beat = is_wr && mode.wr_single;
  assign s_fp     = mode.full_pg && !one_beat;
  assign s_mask   = one_beat ? '0 : CW'((1 << mode.len_lg) - 1);
  assign nb       = beat_q + 1'b1;

  col_order #(.CW(CW)) u_order (
    .base(base_q), .beat(nb), .mask(mask_q),
    .full_pg(fp_q), .ilv(ilv_q), .addr(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q   <= '0;
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      fp_q    <= 1'b0;
      ilv_q   <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (start) begin
      col_q   <= start_col;
      base_q  <= start_col;
      beat_q  <= '0;
      mask_q  <= s_mask;
      fp_q    <= s_fp;
      ilv_q   <= mode.ilv;
      valid_q <= 1'b1;
      last_q  <= !s_fp && (s_mask == '0);
    end else if (stop) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (step && valid_q) begin
      if (last_q) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end else begin
        col_q  <= nxt;
        beat_q <= nb;
        last_q <= !fp_q && (nb == mask_q);
      end
    end
  end

  AST_FP_NO_LAST: assert property (@(posedge clk) disable iff (rst)
    (valid_q && fp_q) |-> !last_q); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !step && !start && !stop) |=> (valid_q && $stable(col_q))); // R10

  AST_FINAL_STEP: assert property (@(posedge clk) disable iff (rst)
    (valid_q && last_q && step && !start && !stop) |=> !valid_q); // R7

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int BAW = BA_W,
  parameter int CW  = COL_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_load,
  input  logic [OPW-1:0] mode_op,
  input  logic [BAW-1:0] mode_ba,
  input  logic           burst_start,
  input  logic           burst_is_write,
  input  logic [CW-1:0]  start_col,
  input  logic           step_en,
  input  logic           burst_stop,
  output logic [CW-1:0]  col_out,
  output logic           col_valid,
  output logic           col_last,
  output logic [1:0]     cas_lat,
  output logic           single_write,
  output logic           mode_err
);

  mode_t mode;

  mode_store #(.OPW(OPW), .BAW(BAW)) u_mode (
    .clk(clk), .rst(rst), .load(mode_load), .op(mode_op), .ba(mode_ba),
    .mode_q(mode), .err_q(mode_err)
  );

  beat_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst(rst), .mode(mode), .start(burst_start),
    .is_wr(burst_is_write), .start_col(start_col), .step(step_en),
    .stop(burst_stop), .col_q(col_out), .valid_q(col_valid), .last_q(col_last)
  );

  assign cas_lat      = mode.cl;
  assign single_write = mode.wr_single;

  AST_START_COL: assert property (@(posedge clk) disable iff (rst)
    burst_start |=> (col_valid && col_out == $past(start_col))); // R4

  AST_LAST_VALID: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid); // R7

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (burst_stop && !burst_start) |=> (!col_valid && !col_last)); // R9

endmodule

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_load = 1'b0;
  logic [11:0] mode_op = '0;
  logic [1:0] mode_ba = '0;
  logic       burst_start = 1'b0, burst_is_write = 1'b0;
  logic [9:0] start_col = '0;
  logic       step_en = 1'b0, burst_stop = 1'b0;
  logic [9:0] col_out;
  logic       col_valid, col_last, single_write, mode_err;
  logic [1:0] cas_lat;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  burst_col_gen dut_i (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_op(mode_op),
    .mode_ba(mode_ba), .burst_start(burst_start), .burst_is_write(burst_is_write),
    .start_col(start_col), .step_en(step_en), .burst_stop(burst_stop),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last),
    .cas_lat(cas_lat), .single_write(single_write), .mode_err(mode_err)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mk_op(input int bl, input int bt, input int cl, input int wm);
    return 12'((wm << 9) | (cl << 4) | (bt << 3) | bl);
  endfunction

  task automatic load(input logic [11:0] op, input logic [1:0] ba);
    mode_op = op; mode_ba = ba; mode_load = 1'b1;
    tick();
    mode_load = 1'b0; mode_ba = '0;
  endtask

  task automatic start(input int col, input bit wr);
    start_col = 10'(col); burst_is_write = wr; burst_start = 1'b1;
    tick();
    burst_start = 1'b0;
  endtask

  function automatic int exp_col(input int s, input int k, input int len, input bit fp, input bit ilv);
    int m;
    m = len - 1;
    if (fp)  return (s + k) % 1024;
    if (ilv) return s ^ k;
    return (s & ~m & 1023) | ((s + k) & m);
  endfunction

  // full fixed-length burst with continuous steps
  task automatic run_burst(input string req, input int s, input bit wr, input int len, input bit ilv);
    start(s, wr);
    for (int k = 0; k < len; k++) begin
      if (k > 0) begin step_en = 1'b1; tick(); end
      chk({req, " col"}, col_out, exp_col(s, k, len, 1'b0, ilv));
      chk({req, " valid"}, col_valid, 1);
      chk({req, " last"}, col_last, (k == len - 1));
    end
    step_en = 1'b1; tick(); step_en = 1'b0;
    chk({req, " end R7"}, col_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 valid", col_valid, 0);
    chk("R1 last", col_last, 0);
    chk("R1 err", mode_err, 0);
    chk("R1 cl", cas_lat, 2);
    chk("R1 wm", single_write, 0);
    run_burst("R1 default len1", 37, 1'b0, 1, 1'b0);
  endtask

  task automatic t_decode();
    load(mk_op(3, 0, 3, 1), 2'b00);
    chk("R2 cl3", cas_lat, 3);
    chk("R2 wm1", single_write, 1);
    chk("R2 err", mode_err, 0);
    load(mk_op(3, 0, 2, 0), 2'b00);
    chk("R2 cl2", cas_lat, 2);
    chk("R2 wm0", single_write, 0);
  endtask

  task automatic t_reserved();
    load(mk_op(5, 0, 3, 1), 2'b00);
    chk("R3 bl101 err", mode_err, 1);
    chk("R3 bl101 cl kept", cas_lat, 2);
    chk("R3 bl101 wm kept", single_write, 0);
    load(mk_op(2, 0, 4, 0), 2'b00);
    chk("R3 cl100 err", mode_err, 1);
    load(mk_op(2, 0, 3, 0), 2'b10);
    chk("R3 ba err", mode_err, 1);
    chk("R3 ba cl kept", cas_lat, 2);
    load(mk_op(7, 1, 3, 0), 2'b00);
    chk("R3 fp+ilv err", mode_err, 1);
    load(mk_op(2, 0, 3, 0) | 12'h100, 2'b00);
    chk("R3 bit8 err", mode_err, 1);
    run_burst("R3 length kept 8", 5, 1'b0, 8, 1'b0);
    load(mk_op(3, 0, 2, 0), 2'b00);
    chk("R3 cleared", mode_err, 0);
  endtask

  task automatic t_orders();
    load(mk_op(3, 0, 2, 0), 2'b00);
    run_burst("R5 seq8 s5", 5, 1'b0, 8, 1'b0);
    run_burst("R5 seq8 upper", 10'h3FD, 1'b0, 8, 1'b0);
    load(mk_op(2, 0, 2, 0), 2'b00);
    run_burst("R5 seq4 s6", 6, 1'b1, 4, 1'b0);
    load(mk_op(3, 1, 2, 0), 2'b00);
    run_burst("R6 ilv8 s5", 5, 1'b0, 8, 1'b1);
    load(mk_op(1, 1, 2, 0), 2'b00);
    run_burst("R6 ilv2 s3", 10'h203, 1'b0, 2, 1'b1);
  endtask

  task automatic t_fullpage();
    load(mk_op(7, 0, 3, 0), 2'b00);
    start(10'h3FD, 1'b0);
    for (int k = 0; k < 6; k++) begin
      if (k > 0) begin step_en = 1'b1; tick(); end
      chk("R8 fp col", col_out, exp_col(10'h3FD, k, 1024, 1'b1, 1'b0));
      chk("R8 fp nolast", col_last, 0);
    end
    step_en = 1'b0;
    burst_stop = 1'b1; tick(); burst_stop = 1'b0;
    chk("R9 stop valid", col_valid, 0);
    chk("R9 stop last", col_last, 0);
  endtask

  task automatic t_hold_and_prio();
    load(mk_op(2, 0, 2, 0), 2'b00);
    start(20, 1'b0);
    step_en = 1'b1; tick(); step_en = 1'b0;
    tick(); tick();
    chk("R10 hold col", col_out, 21);
    chk("R10 hold valid", col_valid, 1);
    burst_stop = 1'b1; start_col = 10'd40; burst_start = 1'b1;
    tick();
    burst_stop = 1'b0; burst_start = 1'b0;
    chk("R9 prio valid", col_valid, 1);
    chk("R9 prio col", col_out, 40);
    step_en = 1'b1; tick(); step_en = 1'b0;
    chk("R13 before restart", col_out, 41);
    start(9, 1'b0);
    chk("R13 restart col", col_out, 9);
    chk("R13 restart last", col_last, 0);
    step_en = 1'b1; tick(); step_en = 1'b0;
    chk("R13 restart next", col_out, 10);
    burst_stop = 1'b1; tick(); burst_stop = 1'b0;
  endtask

  task automatic t_single_write();
    load(mk_op(2, 0, 2, 1), 2'b00);
    run_burst("R11 write single", 6, 1'b1, 1, 1'b0);
    run_burst("R11 read len4", 6, 1'b0, 4, 1'b0);
  endtask

  task automatic t_latched();
    load(mk_op(2, 0, 2, 0), 2'b00);
    start(2, 1'b0);
    load(mk_op(3, 1, 2, 0), 2'b00);
    for (int k = 1; k < 4; k++) begin
      step_en = 1'b1; tick();
      chk("R12 col", col_out, exp_col(2, k, 4, 1'b0, 1'b0));
      chk("R12 last", col_last, (k == 3));
    end
    tick(); step_en = 1'b0;
    chk("R12 end", col_valid, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_decode();
    t_reserved();
    t_orders();
    t_fullpage();
    t_hold_and_prio();
    t_single_write();
    t_latched();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule